// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter

This block turns a stream of bytes into a bit-serial HDLC line signal. Bytes are written into a small transmit FIFO. Each write can carry two one-shot tags. One tag marks the byte as the last of its packet. The other tag replaces the byte with an abort. The transmitter frames each packet with flags, inserts zero bits so that data never looks like a flag, and sends a selectable fill pattern between packets. It moves one bit on each clock cycle in which the bit enable is high. An output-enable pin carries the tri-state of the serial line.

A two-bit fill selector picks what goes on the line between packets: idle ones, back-to-back flags, a repeated go-ahead byte, or transparent mode. In transparent mode the FIFO bytes go out raw, with no framing. The transmit enable acts on whole packets, so a packet that has started always finishes before the line is released. In transparent mode the transmit enable instead stops the line almost at once. Frame check sequence generation is left to the logic around this block.

Top module: `hdlc_tx_core`

## Requirements
- R1: After reset, and while `tx_en_i` is low with no packet in progress, `ser_oe_o` is 0 and `ser_o` is 1.
- R2: The serial outputs change only on the clock edge after a cycle with `bit_en_i` high, and each such cycle sends exactly one line bit.
- R3: A packet starts with the flag 0x7E and ends with a closing 0x7E flag placed right after the byte pushed with the end-of-packet tag. All bytes, flags included, are sent LSB first, so a flag appears on the line as 0,1,1,1,1,1,1,0.
- R4: Between the opening and closing flags, a 0 is inserted after every five consecutive data ones, counted across byte boundaries. Flags, abort, idle and go-ahead patterns are never stuffed.
- R5: With `fill_sel_i` = 00, the line sends continuous ones between packets.
- R6: With `fill_sel_i` = 01, the line sends back-to-back 0x7E flags between packets.
- R7: With `fill_sel_i` = 11, the line repeats 0x7F between packets (line bits 1,1,1,1,1,1,1,0).
- R8: When a byte pushed with the abort tag reaches the head of the FIFO, that byte is dropped and eight ones are sent in its place. The packet ends there and the next FIFO byte starts a new packet.
- R9: If the FIFO is empty when the next data byte of an open packet is needed, eight ones are sent and the packet ends.
- R10: A pulse on `eop_set_i` or `abort_set_i` is held until the next accepted push, which takes the tag; that push clears the request. A pulse in the same cycle as a push tags that push.
- R11: If `tx_en_i` falls during a packet, the packet is sent in full through its closing flag (or abort). `ser_oe_o` falls on the bit period right after that.
- R12: With `fill_sel_i` = 10 (transparent), FIFO bytes are sent LSB first with no flags and no stuffing. Ones are sent in whole 8-bit groups while the FIFO is empty.
- R13: In transparent mode, `ser_oe_o` is 0 no later than the second enabled bit period after `tx_en_i` goes low.
- R14: `full_o` is high when the FIFO holds `FIFO_DEPTH` bytes, and a push while `full_o` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-period enable; one line bit per high cycle |
| tx_en_i | input | 1 | Packet-level transmit enable |
| fill_sel_i | input | 2 | Fill select: 00 ones, 01 flags, 10 transparent, 11 go-ahead |
| push_i | input | 1 | Write `push_data_i` into the FIFO |
| push_data_i | input | 8 | Byte to write |
| eop_set_i | input | 1 | Request the end-of-packet tag for the next push |
| abort_set_i | input | 1 | Request the abort tag for the next push |
| full_o | output | 1 | FIFO full |
| ser_o | output | 1 | Serial data, held at 1 when not driven |
| ser_oe_o | output | 1 | Serial output enable (0 = high impedance) |

## Verification
The hardest case to reach is a stuffing decision that falls exactly on a byte boundary or directly before a closing flag or an abort. To reach it, the stimulus uses bytes that end in runs of ones (0xFF, 0x1F, 0xF8), alongside random bytes biased toward high bit density. A second hard case is a late transmit-disable, because the packet must already be open when the enable drops. The bench watches the line for the opening flag's leading zero before it lowers `tx_en_i`. Every frame is rebuilt from the recorded line by an independent destuffing decoder, and the stuffed-bit count is checked against the count computed from the data.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [BYTE_W-1:0] ONES_PAT  = 8'hFF;
  localparam logic [BYTE_W-1:0] GA_PAT    = 8'h7F;

  typedef enum logic [1:0] {
    FILL_ONES  = 2'b00,
    FILL_FLAGS = 2'b01,
    FILL_XP    = 2'b10,
    FILL_GA    = 2'b11
  } fill_e;

  typedef enum logic [2:0] {
    K_OFF, K_FILL, K_FLAG, K_DATA, K_ABORT, K_XP
  } kind_e;

  typedef struct packed {
    logic              abort;
    logic              eop;
    logic [BYTE_W-1:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  fifo_ent_t     push_ent_i,
  input  logic          pop_i,
  output fifo_ent_t     head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  fifo_ent_t mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       tx_en_i,
  input  logic [1:0] fill_sel_i,
  input  fifo_ent_t  head_i,
  input  logic       empty_i,
  output logic       pop_o,
  output logic       ser_o,
  output logic       oe_o,
  output logic       xp_o,
  output logic       in_pkt_o
);
  logic [BYTE_W-1:0] pat_q, pat_n, cur_pat;
  logic [3:0]        left_q, left_n;
  kind_e             kind_q, kind_n, cur_kind;
  logic [2:0]        ones_q, ones_n;
  logic              in_pkt_q, in_pkt_n, last_q, last_n;
  logic              ser_q, ser_n, oe_q, oe_n;

  always_comb begin
    pat_n = pat_q;  left_n = left_q;  kind_n = kind_q;  ones_n = ones_q;
    in_pkt_n = in_pkt_q;  last_n = last_q;  ser_n = ser_q;  oe_n = oe_q;
    pop_o = 1'b0;  cur_pat = pat_q;  cur_kind = kind_q;
    if (bit_en_i) begin
      if (kind_q == K_XP && !tx_en_i) begin
        // transparent stop: drop the byte in flight
        kind_n = K_OFF;  left_n = '0;  oe_n = 1'b0;  ser_n = 1'b1;
      end else if (kind_q == K_DATA && ones_q == 3'd5) begin
        // stuffed zero, pattern not consumed
        ser_n = 1'b0;  oe_n = 1'b1;  ones_n = '0;
      end else begin
        if (left_q == '0) begin
          if (in_pkt_q) begin
            if (last_q) begin
              cur_pat = FLAG_PAT;  cur_kind = K_FLAG;  in_pkt_n = 1'b0;
            end else if (empty_i || head_i.abort) begin
              cur_pat = ONES_PAT;  cur_kind = K_ABORT;  in_pkt_n = 1'b0;
              pop_o = !empty_i;
            end else begin
              cur_pat = head_i.data;  cur_kind = K_DATA;  pop_o = 1'b1;
              last_n = head_i.eop;
            end
          end else if (!tx_en_i) begin
            cur_kind = K_OFF;
          end else if (fill_sel_i == FILL_XP) begin
            cur_kind = K_XP;
            cur_pat  = empty_i ? ONES_PAT : head_i.data;
            pop_o    = !empty_i;
          end else if (!empty_i) begin
            if (head_i.abort) begin
              cur_pat = ONES_PAT;  cur_kind = K_ABORT;  pop_o = 1'b1;
            end else begin
              cur_pat = FLAG_PAT;  cur_kind = K_FLAG;
              in_pkt_n = 1'b1;  last_n = 1'b0;
            end
          end else begin
            cur_kind = K_FILL;
            unique case (fill_sel_i)
              FILL_FLAGS: cur_pat = FLAG_PAT;
              FILL_GA:    cur_pat = GA_PAT;
              default:    cur_pat = ONES_PAT;
            endcase
          end
        end
        if (cur_kind == K_OFF) begin
          kind_n = K_OFF;  left_n = '0;  oe_n = 1'b0;  ser_n = 1'b1;  ones_n = '0;
        end else begin
          ser_n  = cur_pat[0];
          oe_n   = 1'b1;
          pat_n  = {1'b0, cur_pat[BYTE_W-1:1]};
          left_n = (left_q == '0) ? 4'(BYTE_W - 1) : left_q - 4'd1;
          kind_n = cur_kind;
          if (cur_kind == K_DATA) ones_n = cur_pat[0] ? ones_q + 3'd1 : '0;
          else                    ones_n = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q <= '0;  left_q <= '0;  kind_q <= K_OFF;  ones_q <= '0;
      in_pkt_q <= 1'b0;  last_q <= 1'b0;  ser_q <= 1'b1;  oe_q <= 1'b0;
    end else begin
      pat_q <= pat_n;  left_q <= left_n;  kind_q <= kind_n;  ones_q <= ones_n;
      in_pkt_q <= in_pkt_n;  last_q <= last_n;  ser_q <= ser_n;  oe_q <= oe_n;
    end
  end

  assign ser_o    = ser_q;
  assign oe_o     = oe_q;
  assign xp_o     = (kind_q == K_XP);
  assign in_pkt_o = in_pkt_q;
endmodule

// File: rtl/hdlc_tx_core.sv
module hdlc_tx_core
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              tx_en_i,
  input  logic [1:0]        fill_sel_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              eop_set_i,
  input  logic              abort_set_i,
  output logic              full_o,
  output logic              ser_o,
  output logic              ser_oe_o
);
  logic eop_pend_q, abort_pend_q, push_ok, pop, empty, in_pkt, xp_act;
  fifo_ent_t push_ent, head;
  logic [CW-1:0] fifo_cnt;

  assign push_ok  = push_i && !full_o;
  assign push_ent = '{abort: abort_pend_q | abort_set_i,
                      eop:   eop_pend_q | eop_set_i,
                      data:  push_data_i};

  // one-shot tag requests, consumed by the next accepted push
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eop_pend_q   <= 1'b0;
      abort_pend_q <= 1'b0;
    end else if (push_ok) begin
      eop_pend_q   <= 1'b0;
      abort_pend_q <= 1'b0;
    end else begin
      if (eop_set_i)   eop_pend_q   <= 1'b1;
      if (abort_set_i) abort_pend_q <= 1'b1;
    end
  end

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .push_i(push_i), .push_ent_i(push_ent), .pop_i(pop),
    .head_o(head), .empty_o(empty), .full_o(full_o), .count_o(fifo_cnt)
  );

  hdlc_tx_ser ser_i (
    .clk_i, .rst_ni, .bit_en_i, .tx_en_i, .fill_sel_i,
    .head_i(head), .empty_i(empty), .pop_o(pop),
    .ser_o(ser_o), .oe_o(ser_oe_o), .xp_o(xp_act), .in_pkt_o(in_pkt)
  );
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_en_i,
  input logic          tx_en_i,
  input logic          push_i,
  input logic          eop_set_i,
  input logic          full_o,
  input logic          pop,
  input logic [CW-1:0] fifo_cnt,
  input logic          ser_o,
  input logic          ser_oe_o,
  input logic          xp_act,
  input logic          in_pkt,
  input logic          eop_pend_q
);
  // R2
  bit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(ser_o) && $stable(ser_oe_o)));

  // R11
  pkt_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && in_pkt) |=> ser_oe_o);

  // R13
  xp_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !tx_en_i && xp_act) |=> !ser_oe_o);

  // R14
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop) |=> $stable(fifo_cnt));

  // R14
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  // R10
  tag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !eop_set_i) |=> !eop_pend_q);

  // R1
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_oe_o |-> ser_o);
endmodule

bind hdlc_tx_core hdlc_tx_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .tx_en_i(tx_en_i),
  .push_i(push_i), .eop_set_i(eop_set_i), .full_o(full_o), .pop(pop),
  .fifo_cnt(fifo_cnt), .ser_o(ser_o), .ser_oe_o(ser_oe_o), .xp_act(xp_act),
  .in_pkt(in_pkt), .eop_pend_q(eop_pend_q)
);

// File: tb/hdlc_tx_core_tb.sv
module hdlc_tx_core_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0, bit_en = 1'b1, tx_en = 1'b0;
  logic [1:0] fill_sel = 2'b00;
  logic push = 1'b0, eop_set = 1'b0, abort_set = 1'b0;
  logic [7:0] push_data = '0;
  logic full, ser, oe;

  int n_chk = 0, n_fail = 0;
  int bitq[$];
  logic [7:0] exp_q[$];
  logic [7:0] dec_bytes[$];
  int dec_ok, dec_abort, dec_end, dec_start;
  bit rnd_bits = 0, bit_force = 1;

  always #2 clk = ~clk;

  hdlc_tx_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .tx_en_i(tx_en),
    .fill_sel_i(fill_sel), .push_i(push), .push_data_i(push_data),
    .eop_set_i(eop_set), .abort_set_i(abort_set), .full_o(full),
    .ser_o(ser), .ser_oe_o(oe)
  );

  // line monitor: 0/1 driven bits, 2 = high impedance
  initial forever begin
    logic tk;
    @(posedge clk);
    tk = bit_en && rst_ni;
    #1;
    if (tk) bitq.push_back(oe ? int'(ser) : 2);
  end

  initial forever begin
    @(negedge clk);
    bit_en = rnd_bits ? ($urandom % 4 != 0) : bit_force;
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    int target = bitq.size() + n;
    while (bitq.size() < target) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; push = 0; eop_set = 0; abort_set = 0; tx_en = 0; fill_sel = 2'b00;
    cycles(3);
    rst_ni = 1'b1;
  endtask

  task automatic push_byte(input logic [7:0] d, input bit e, input bit a, input bit force_it);
    @(negedge clk);
    while (full && !force_it) @(negedge clk);
    push = 1; push_data = d; eop_set = e; abort_set = a;
    @(negedge clk);
    push = 0; eop_set = 0; abort_set = 0;
  endtask

  task automatic push_frame();
    foreach (exp_q[k]) push_byte(exp_q[k], k == exp_q.size() - 1, 0, 0);
  endtask

  function automatic int stuff_count();
    int ones = 0, cnt = 0;
    foreach (exp_q[k])
      for (int j = 0; j < 8; j++) begin
        if (exp_q[k][j]) ones++; else ones = 0;
        if (ones == 5) begin cnt++; ones = 0; end
      end
    return cnt;
  endfunction

  // independent frame decoder over recorded line bits
  task automatic decode(input int start);
    int i, ones, nb, b, found, closed;
    logic bb[$];
    dec_ok = 0; dec_abort = 0; dec_bytes.delete(); dec_end = start;
    found = 0; closed = 0; nb = 0; i = start;
    while (!found && i + 8 <= bitq.size()) begin
      found = (bitq[i] == 0 && bitq[i+7] == 0) ? 1 : 0;
      for (int j = 1; j < 7; j++) if (bitq[i+j] != 1) found = 0;
      if (!found) i++;
    end
    if (!found) return;
    dec_start = i; i += 8; ones = 0;
    while (i < bitq.size()) begin
      b = bitq[i]; i++;
      if (b == 2) return;
      if (b == 1) begin
        ones++; bb.push_back(1'b1);
        if (ones == 7) begin dec_abort = 1; nb = (bb.size() - 7) / 8; break; end
      end else if (ones == 5) begin
        ones = 0;
      end else if (ones == 6) begin
        repeat (7) void'(bb.pop_back());
        if (bb.size() % 8 != 0) return;
        nb = bb.size() / 8; closed = 1; break;
      end else begin
        bb.push_back(1'b0); ones = 0;
      end
    end
    if (!closed && !dec_abort) return;
    for (int k = 0; k < nb; k++) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[j] = bb[8*k + j];
      dec_bytes.push_back(v);
    end
    dec_ok = 1; dec_end = i;
  endtask

  task automatic chk_frame(input string req, input int exp_abort);
    bit ok = (dec_ok == 1) && (dec_abort == exp_abort) && (dec_bytes.size() == exp_q.size());
    int act = dec_ok * 256 + dec_abort * 16 + dec_bytes.size();
    if (ok) foreach (exp_q[k]) if (dec_bytes[k] !== exp_q[k]) begin
      ok = 0; act = dec_bytes[k];
    end
    chk(ok, req, act, 256 + exp_abort * 16 + exp_q.size());
  endtask

  function automatic bit window_match(input logic [7:0] pat, input int len);
    int base = bitq.size() - len;
    for (int k = 0; k < 8; k++) begin
      bit ok = 1;
      for (int j = 0; j < len; j++) if (bitq[base+j] != int'(pat[(j+k)%8])) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  initial begin
    int cur, m, idx, ok;
    logic hold_s, hold_oe;
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset state and disabled line
    cur = bitq.size();
    cycles(12);
    chk(oe == 0 && ser == 1, "R1 reset", {oe, ser}, 1);
    ok = (bitq.size() > cur + 8);
    for (int k = cur; k < bitq.size(); k++) if (bitq[k] != 2) ok = 0;
    chk(ok, "R1 tristate while disabled", ok, 1);

    // R5 idle ones
    tx_en = 1;
    wait_ticks(24);
    ok = 1;
    for (int k = bitq.size() - 16; k < bitq.size(); k++) if (bitq[k] != 1) ok = 0;
    chk(ok, "R5 idle ones", ok, 1);

    // R6 continuous flags, R7 go-ahead
    fill_sel = 2'b01; wait_ticks(40);
    chk(window_match(8'h7E, 24), "R6 flag fill", 0, 1);
    fill_sel = 2'b11; wait_ticks(40);
    chk(window_match(8'h7F, 24), "R7 go-ahead fill", 0, 1);
    fill_sel = 2'b00; wait_ticks(16);

    // R3 framing, R4 stuffing incl. boundary and before closing flag
    cur = bitq.size();
    exp_q = '{8'h3C, 8'hFF, 8'h1F, 8'hF8, 8'h7E, 8'hF8};
    push_frame(); wait_ticks(150);
    decode(cur);
    chk_frame("R3 frame", 0);
    chk(dec_end - dec_start == 16 + 8 * exp_q.size() + stuff_count(), "R4 stuffed length",
        dec_end - dec_start, 16 + 8 * exp_q.size() + stuff_count());

    // R8 abort tag replaces byte, next packet follows
    cur = bitq.size();
    push_byte(8'h11, 0, 0, 0); push_byte(8'h22, 0, 0, 0);
    push_byte(8'h33, 0, 1, 0); push_byte(8'h44, 1, 0, 0);
    wait_ticks(200);
    decode(cur); exp_q = '{8'h11, 8'h22};
    chk_frame("R8 aborted frame", 1);
    decode(dec_end); exp_q = '{8'h44};
    chk_frame("R8 frame after abort", 0);

    // R9 underrun abort
    cur = bitq.size();
    push_byte(8'h55, 0, 0, 0); push_byte(8'h66, 0, 0, 0);
    wait_ticks(120);
    decode(cur); exp_q = '{8'h55, 8'h66};
    chk_frame("R9 underrun", 1);

    // R10 tag held until next push, then cleared
    cur = bitq.size();
    @(negedge clk); eop_set = 1; @(negedge clk); eop_set = 0;
    cycles(3);
    push_byte(8'hA1, 0, 0, 0); push_byte(8'hB2, 0, 0, 0); push_byte(8'hC3, 1, 0, 0);
    wait_ticks(200);
    decode(cur); exp_q = '{8'hA1};
    chk_frame("R10 held tag", 0);
    decode(dec_end); exp_q = '{8'hB2, 8'hC3};
    chk_frame("R10 tag cleared", 0);

    // R14 full FIFO drops push
    tx_en = 0; wait_ticks(20);
    exp_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    push_frame();
    chk(full == 1, "R14 full flag", full, 1);
    push_byte(8'hEE, 0, 0, 1);
    cur = bitq.size();
    tx_en = 1; wait_ticks(150);
    decode(cur);
    chk_frame("R14 frame intact", 0);
    ok = (bitq.size() > dec_end + 20);
    for (int k = dec_end; k < bitq.size(); k++) if (bitq[k] != 1) ok = 0;
    chk(ok, "R14 dropped byte not sent", ok, 1);

    // R11 disable mid-packet completes frame, then tristate
    cur = bitq.size();
    exp_q = '{8'hF0, 8'h0F, 8'hAA, 8'h55};
    push_frame();
    idx = cur;
    while (1) begin
      while (idx >= bitq.size()) @(negedge clk);
      if (bitq[idx] == 0) break;
      idx++;
    end
    tx_en = 0; wait_ticks(150);
    decode(cur);
    chk_frame("R11 frame completes", 0);
    chk(dec_ok == 1 && bitq[dec_end] == 2, "R11 tristate after flag", bitq[dec_end], 2);

    // R12 transparent data
    fill_sel = 2'b10;
    push_byte(8'hA5, 0, 0, 0); push_byte(8'h0F, 0, 0, 0); push_byte(8'hFF, 0, 0, 0);
    cur = bitq.size();
    tx_en = 1; wait_ticks(40);
    idx = cur;
    while (bitq[idx] == 2) idx++;
    exp_q = '{8'hA5, 8'h0F, 8'hFF, 8'hFF};
    ok = 1;
    for (int k = 0; k < 32; k++) if (bitq[idx+k] != int'(exp_q[k/8][k%8])) ok = 0;
    chk(ok, "R12 transparent bits", ok, 1);

    // R13 transparent stop
    push_byte(8'h00, 0, 0, 0); push_byte(8'h00, 0, 0, 0);
    wait_ticks(12);
    @(negedge clk); tx_en = 0; m = bitq.size();
    wait_ticks(10);
    idx = m;
    while (idx < bitq.size() && bitq[idx] != 2) idx++;
    chk(idx - m <= 1, "R13 stop latency", idx - m, 1);

    // R2 bit enable gating
    do_reset();
    tx_en = 1; fill_sel = 2'b01;
    wait_ticks(20);
    @(negedge clk); bit_force = 0;
    @(negedge clk);
    hold_s = ser; hold_oe = oe; m = bitq.size(); ok = 1;
    repeat (20) begin
      @(negedge clk);
      if (ser !== hold_s || oe !== hold_oe) ok = 0;
    end
    chk(ok && bitq.size() == m, "R2 gated hold", ok, 1);
    bit_force = 1;

    // random frames with sparse bit enable (R2 R3 R4)
    do_reset();
    tx_en = 1; rnd_bits = 1;
    wait_ticks(16);
    cur = bitq.size();
    for (int f = 0; f < 25; f++) begin
      int len = 1 + $urandom % 6;
      exp_q.delete();
      for (int k = 0; k < len; k++) begin
        logic [31:0] r = $urandom;
        exp_q.push_back(r[1:0] == 0 ? 8'hFF : (r[15:8] | (r[2] ? 8'hF0 : 8'h00)));
      end
      push_frame(); wait_ticks(110);
      decode(cur);
      chk_frame("R3 R4 random frame", 0);
      if (dec_ok == 1) cur = dec_end; else cur = bitq.size();
    end
    rnd_bits = 0;

    summary();
    $finish;
  end
endmodule